// File: doc/BRIEF.md
# Serial ADC Read Controller

This block sits on the host side of a 12-bit serial analog-to-digital converter and collects one result after each conversion. The converter signals that it is converting by holding BUSY high. The controller sees BUSY fall, either on every cycle (edge mode) or at a fixed poll interval (poll mode). It then runs one burst of exactly sixteen serial clock pulses. The clock rests low outside the burst, and it is gated onward by an active-high select so that the converter sees no edges while it is deselected.

The converter changes its data line after each rising clock edge. The controller samples the data line at the moment its clock falls. Each frame carries four leading zeros and then twelve result bits, most significant first. Only the last twelve samples are kept, so the leading bits have no effect on the result. The high phase of the clock can be set in system cycles, to cover gate skew, data access and setup. A relaxed mode runs a short, symmetric clock, where the first sample may be corrupt.

Each finished frame produces a one-cycle strobe. The result is held until the next frame ends and can be presented bit-reversed for hosts that read data least significant first. A BUSY event that arrives during a frame is remembered and served after that frame.

Top module: `adc_rd_ctrl`

## Requirements
- R1: In edge mode (`cfg_poll_i`=0), each falling edge of `busy_i` causes exactly one read frame. While `busy_i` holds a steady level, no frame starts.
- R2: In poll mode (`cfg_poll_i`=1), `busy_i` is examined once every POLL_CYC cycles. A frame starts when a poll finds it low and the previous poll found it high.
- R3: A frame contains exactly 16 rising edges of the serial clock. The serial clock is low whenever no frame is running.
- R4: In normal timing (`cfg_relaxed_i`=0), every high phase lasts `cfg_hi_cyc_i` system cycles, and a value of 0 acts as 1. Every low phase lasts LO_CYC cycles.
- R5: While `sel_i` is 0, `sclk_o` stays 0.
- R6: The data line is sampled as the serial clock falls, MSB first. `result_o` is the last 12 samples of the frame, and the values of the first four bits have no effect on it.
- R7: In relaxed timing (`cfg_relaxed_i`=1), each high phase lasts LO_CYC cycles, whatever `cfg_hi_cyc_i` holds. A corrupt first sample does not change the result.
- R8: `result_valid_o` is high for exactly one cycle per frame. `result_o` changes only in that cycle and otherwise holds its value.
- R9: With `cfg_lsb_first_i`=1, `result_o` is bit-reversed: bit 0 carries the first data bit (the MSB), and bit 11 carries the last.
- R10: A BUSY event that arrives during a frame, including one in the cycles around the end of a frame, yields exactly one further frame after the current one. Frames never overlap.
- R11: Reset returns the block to idle, with `sclk_o` at 0, `result_valid_o` at 0 and `result_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| busy_i | input | 1 | Converter busy flag, high while converting |
| sdata_i | input | 1 | Serial data from the converter |
| sel_i | input | 1 | Active-high select that gates the serial clock |
| cfg_poll_i | input | 1 | 1 = poll mode, 0 = edge mode |
| cfg_relaxed_i | input | 1 | 1 = short symmetric clock (relaxed timing) |
| cfg_lsb_first_i | input | 1 | 1 = present the result bit-reversed |
| cfg_hi_cyc_i | input | 4 | High-phase length in system cycles (0 treated as 1) |
| sclk_o | output | 1 | Gated serial clock to the converter |
| result_o | output | 12 | Last captured result |
| result_valid_o | output | 1 | One-cycle strobe when a frame completes |

## Verification
Two things can land in the same cycle: a new BUSY event, and the end of the current frame, which includes both the result strobe and the return of the sequencer to idle. The bench raises BUSY during a frame. It then waits for the result strobe and releases BUSY after a delay that sweeps from zero cycles to past the trailing low phase, so that the event lands before, on and after the cycle in which the sequencer goes idle. Each sweep point passes only if exactly two strobes appear, each with the correct result, and no third frame follows.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_HIGH = 2'd1,
    SQ_LOW  = 2'd2
  } sq_state_t;

endpackage

// File: rtl/rd_busy_watch.sv
module rd_busy_watch #(
  parameter int SYNC_STAGES = 2,
  parameter int POLL_CYC    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic poll_mode_i,
  input  logic take_i,
  output logic pend_o
);

  localparam int POLL_W = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   busy_s;
  logic                   edge_d_q;
  logic [POLL_W-1:0]      poll_cnt_q, poll_cnt_d;
  logic                   poll_tick;
  logic                   poll_seen_q, poll_seen_d;
  logic                   evt;
  logic                   pend_q, pend_d;

  // metastability chain for the asynchronous busy flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= busy_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign busy_s    = sync_q[SYNC_STAGES-1];
  assign poll_tick = (poll_cnt_q == POLL_W'(POLL_CYC - 1));

  always_comb begin
    poll_cnt_d  = poll_tick ? '0 : poll_cnt_q + POLL_W'(1);
    poll_seen_d = poll_tick ? busy_s : poll_seen_q;
    if (poll_mode_i) evt = poll_tick & poll_seen_q & ~busy_s;
    else             evt = edge_d_q & ~busy_s;
    pend_d = (pend_q & ~take_i) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_d_q    <= 1'b0;
      poll_cnt_q  <= '0;
      poll_seen_q <= 1'b0;
      pend_q      <= 1'b0;
    end else begin
      edge_d_q    <= busy_s;
      poll_cnt_q  <= poll_cnt_d;
      poll_seen_q <= poll_seen_d;
      pend_q      <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/rd_sclk_seq.sv
module rd_sclk_seq
  import adc_rd_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int HI_W    = 4,
  parameter int LO_CYC  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [HI_W-1:0] hi_cyc_i,
  output logic            sclk_o,
  output logic            smp_o,
  output logic            last_o,
  output logic            active_o
);

  localparam int LO_W  = (LO_CYC > 1) ? $clog2(LO_CYC) : 1;
  localparam int CNT_W = (HI_W > LO_W) ? HI_W : LO_W;
  localparam int PC_W  = $clog2(FRAME_W + 1);

  sq_state_t        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic             clk_q, clk_d;
  logic [CNT_W-1:0] hi_load;

  assign hi_load = CNT_W'(hi_cyc_i) - CNT_W'(1);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    pc_d   = pc_q;
    clk_d  = clk_q;
    smp_o  = 1'b0;
    last_o = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (start_i) begin
          st_d  = SQ_HIGH;
          clk_d = 1'b1;
          cnt_d = hi_load;
        end
      end
      SQ_HIGH: begin
        if (cnt_q == '0) begin
          smp_o  = 1'b1;
          last_o = (pc_q == PC_W'(FRAME_W - 1));
          st_d   = SQ_LOW;
          clk_d  = 1'b0;
          cnt_d  = CNT_W'(LO_CYC - 1);
          pc_d   = pc_q + PC_W'(1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      SQ_LOW: begin
        if (cnt_q == '0) begin
          if (pc_q == PC_W'(FRAME_W)) begin
            st_d = SQ_IDLE;
            pc_d = '0;
          end else begin
            st_d  = SQ_HIGH;
            clk_d = 1'b1;
            cnt_d = hi_load;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: begin
        st_d  = SQ_IDLE;
        clk_d = 1'b0;
        pc_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      pc_q  <= '0;
      clk_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      pc_q  <= pc_d;
      clk_q <= clk_d;
    end
  end

  assign sclk_o   = clk_q;
  assign active_o = (st_q != SQ_IDLE);

endmodule

// File: rtl/rd_frame_cap.sv
module rd_frame_cap #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_i,
  input  logic              last_i,
  input  logic              sdata_i,
  input  logic              lsb_first_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o
);

  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [DATA_W-1:0] shreg_rev;
  logic [DATA_W-1:0] res_q, res_d;
  logic              last_q;
  logic              valid_q;

  // leading bits fall off the top of the window
  assign shreg_d = smp_i ? {shreg_q[DATA_W-2:0], sdata_i} : shreg_q;

  for (genvar g = 0; g < DATA_W; g++) begin : g_rev
    assign shreg_rev[g] = shreg_q[DATA_W-1-g];
  end

  assign res_d = last_q ? (lsb_first_i ? shreg_rev : shreg_q) : res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      last_q  <= 1'b0;
      res_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      last_q  <= last_i;
      res_q   <= res_d;
      valid_q <= last_q;
    end
  end

  assign result_o = res_q;
  assign valid_o  = valid_q;

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
  parameter int DATA_W      = 12,
  parameter int FRAME_W     = 16,
  parameter int HI_W        = 4,
  parameter int LO_CYC      = 2,
  parameter int POLL_CYC    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              sdata_i,
  input  logic              sel_i,
  input  logic              cfg_poll_i,
  input  logic              cfg_relaxed_i,
  input  logic              cfg_lsb_first_i,
  input  logic [HI_W-1:0]   cfg_hi_cyc_i,
  output logic              sclk_o,
  output logic [DATA_W-1:0] result_o,
  output logic              result_valid_o
);

  logic [1:0]      rst_pipe_q;
  logic            rst_sync_n;
  logic            pend;
  logic            start;
  logic            eng_active;
  logic            sclk_int;
  logic            smp;
  logic            last;
  logic [HI_W-1:0] hi_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign hi_eff = cfg_relaxed_i        ? HI_W'(LO_CYC) :
                  (cfg_hi_cyc_i == '0) ? HI_W'(1)      : cfg_hi_cyc_i;

  assign start = pend & ~eng_active;

  rd_busy_watch #(
    .SYNC_STAGES(SYNC_STAGES),
    .POLL_CYC   (POLL_CYC)
  ) u_watch (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .busy_i     (busy_i),
    .poll_mode_i(cfg_poll_i),
    .take_i     (start),
    .pend_o     (pend)
  );

  rd_sclk_seq #(
    .FRAME_W(FRAME_W),
    .HI_W   (HI_W),
    .LO_CYC (LO_CYC)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start),
    .hi_cyc_i(hi_eff),
    .sclk_o  (sclk_int),
    .smp_o   (smp),
    .last_o  (last),
    .active_o(eng_active)
  );

  rd_frame_cap #(
    .DATA_W(DATA_W)
  ) u_cap (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .smp_i      (smp),
    .last_i     (last),
    .sdata_i    (sdata_i),
    .lsb_first_i(cfg_lsb_first_i),
    .result_o   (result_o),
    .valid_o    (result_valid_o)
  );

  assign sclk_o = sclk_int & sel_i;

endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
  parameter int DATA_W  = 12,
  parameter int FRAME_W = 16,
  parameter int HI_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_int,
  input logic              sclk_o,
  input logic              eng_active,
  input logic [DATA_W-1:0] result_o,
  input logic              result_valid_o,
  input logic [HI_W-1:0]   hi_eff
);

  logic       sclk_d, act_d;
  logic [7:0] rise_cnt;
  logic [7:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      act_d    <= 1'b0;
      rise_cnt <= '0;
      hi_len   <= '0;
    end else begin
      sclk_d <= sclk_int;
      act_d  <= eng_active;
      if (eng_active && !act_d)  rise_cnt <= 8'd1;
      else if (sclk_int && !sclk_d) rise_cnt <= rise_cnt + 8'd1;
      hi_len <= sclk_int ? hi_len + 8'd1 : 8'd0;
    end
  end

  // R8: strobe lasts one cycle
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |=> !result_valid_o);

  // R8: result moves only with the strobe
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid_o |-> $stable(result_o));

  // R3: sixteen pulses delivered by the time the result appears
  a_r3_sixteen_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> (rise_cnt == 8'(FRAME_W)));

  // R3: clock rests low outside a frame
  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_active |-> !sclk_o);

  // R4 / R7: each high phase matches the effective setting
  a_r4_high_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_int) |-> (hi_len == 8'(hi_eff)));

endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
  .DATA_W (DATA_W),
  .FRAME_W(FRAME_W),
  .HI_W   (HI_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .sclk_int      (sclk_int),
  .sclk_o        (sclk_o),
  .eng_active    (eng_active),
  .result_o      (result_o),
  .result_valid_o(result_valid_o),
  .hi_eff        (hi_eff)
);

// File: tb/tb_adc_rd_ctrl.sv
`timescale 1ns/1ps
module tb_adc_rd_ctrl;

  localparam int LO_CYC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busy = 1'b0;
  logic        sdata = 1'b0;
  logic        sel = 1'b1;
  logic        poll = 1'b0;
  logic        relaxed = 1'b0;
  logic        lsb = 1'b0;
  logic [3:0]  hi = 4'd3;
  logic        sclk_o;
  logic [11:0] result;
  logic        valid;

  int checks = 0;
  int errors = 0;
  int valid_cnt = 0;
  int dbl_valid = 0;
  int total_rise = 0;
  int rise_idx = 0;
  int hi_run = 0;
  int last_hi = 0;
  logic        prev_valid = 1'b0;
  logic [15:0] conv_word = 16'h0000;
  logic        glitch = 1'b0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  adc_rd_ctrl #(.LO_CYC(LO_CYC)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy_i         (busy),
    .sdata_i        (sdata),
    .sel_i          (sel),
    .cfg_poll_i     (poll),
    .cfg_relaxed_i  (relaxed),
    .cfg_lsb_first_i(lsb),
    .cfg_hi_cyc_i   (hi),
    .sclk_o         (sclk_o),
    .result_o       (result),
    .result_valid_o (valid)
  );

  // converter model: new bit shortly after each rising serial clock edge
  always @(posedge sclk_o) begin
    int cur;
    if (rise_idx >= 16) rise_idx = 0;
    cur = rise_idx;
    rise_idx = rise_idx + 1;
    total_rise = total_rise + 1;
    #2;
    sdata = (glitch && cur == 0) ? 1'b1 : conv_word[15-cur];
  end

  always @(negedge clk) begin
    if (valid) valid_cnt = valid_cnt + 1;
    if (valid && prev_valid) dbl_valid = dbl_valid + 1;
    prev_valid = valid;
    if (sclk_o) hi_run = hi_run + 1;
    else if (hi_run > 0) begin
      last_hi = hi_run;
      hi_run = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic fire_busy();
    busy = 1'b1;
    repeat (20) @(negedge clk);
    busy = 1'b0;
  endtask

  task automatic wait_valid(input int target);
    for (int i = 0; i < 3000; i++) begin
      if (valid_cnt >= target) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [11:0] rev12(input logic [11:0] v);
    logic [11:0] r;
    for (int i = 0; i < 12; i++) r[i] = v[11-i];
    return r;
  endfunction

  task automatic one_frame(input logic [15:0] w, input logic [11:0] exp, input string req);
    int base_v, base_r;
    base_v = valid_cnt;
    base_r = total_rise;
    conv_word = w;
    fire_busy();
    wait_valid(base_v + 1);
    repeat (10) @(negedge clk);
    chk(valid_cnt == base_v + 1, req, valid_cnt - base_v, 1);
    chk(result == exp, req, int'(result), int'(exp));
    chk(total_rise - base_r == 16, "R3", total_rise - base_r, 16);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(sclk_o == 1'b0, "R11", int'(sclk_o), 0);
    chk(valid == 1'b0, "R11", int'(valid), 0);
    chk(result == 12'h000, "R11", int'(result), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_steady();
    int base_r;
    base_r = total_rise;
    repeat (200) @(negedge clk);
    chk(total_rise == base_r, "R1", total_rise - base_r, 0);
  endtask

  task automatic t_edge_basic();
    poll = 1'b0; hi = 4'd3;
    one_frame(16'h0A5C, 12'hA5C, "R1");
    chk(last_hi == 3, "R4", last_hi, 3);
    chk(dbl_valid == 0, "R8", dbl_valid, 0);
  endtask

  task automatic t_leading();
    one_frame(16'hF123, 12'h123, "R6");
  endtask

  task automatic t_poll();
    poll = 1'b1;
    one_frame(16'h03C7, 12'h3C7, "R2");
    poll = 1'b0;
  endtask

  task automatic t_lsb();
    lsb = 1'b1;
    one_frame(16'h0001, 12'h800, "R9");
    one_frame(16'h0B2D, rev12(12'hB2D), "R9");
    lsb = 1'b0;
  endtask

  task automatic t_hi();
    hi = 4'd5;
    one_frame(16'h0777, 12'h777, "R4");
    chk(last_hi == 5, "R4", last_hi, 5);
    hi = 4'd0;
    one_frame(16'h0111, 12'h111, "R4");
    chk(last_hi == 1, "R4", last_hi, 1);
    hi = 4'd3;
  endtask

  task automatic t_relaxed();
    relaxed = 1'b1; hi = 4'd5; glitch = 1'b1;
    one_frame(16'h0ABC, 12'hABC, "R7");
    chk(last_hi == LO_CYC, "R7", last_hi, LO_CYC);
    relaxed = 1'b0; hi = 4'd3; glitch = 1'b0;
  endtask

  task automatic t_sel();
    int base_r, base_v;
    sel = 1'b0;
    base_r = total_rise;
    base_v = valid_cnt;
    conv_word = 16'h0FFF;
    fire_busy();
    wait_valid(base_v + 1);
    repeat (10) @(negedge clk);
    chk(total_rise == base_r, "R5", total_rise - base_r, 0);
    sel = 1'b1;
    rise_idx = 16;
    one_frame(16'h0456, 12'h456, "R5");
  endtask

  task automatic t_hold();
    logic [11:0] snap;
    int base_v;
    snap = result;
    base_v = valid_cnt;
    repeat (150) @(negedge clk);
    chk(result == snap, "R8", int'(result), int'(snap));
    chk(valid_cnt == base_v, "R8", valid_cnt - base_v, 0);
  endtask

  task automatic t_overlap();
    int base_v, base_r;
    base_v = valid_cnt;
    base_r = total_rise;
    conv_word = 16'h0C3A;
    fire_busy();
    while (total_rise < base_r + 4) @(negedge clk);
    fire_busy();
    wait_valid(base_v + 2);
    repeat (200) @(negedge clk);
    chk(valid_cnt == base_v + 2, "R10", valid_cnt - base_v, 2);
    chk(total_rise - base_r == 32, "R10", total_rise - base_r, 32);
    chk(result == 12'hC3A, "R10", int'(result), 12'hC3A);
  endtask

  task automatic t_collide();
    for (int off = 0; off < 9; off++) begin
      int base_v, base_r;
      base_v = valid_cnt;
      base_r = total_rise;
      conv_word = 16'h0000 | 16'(12'h5A0 + off);
      fire_busy();
      while (total_rise < base_r + 2) @(negedge clk);
      busy = 1'b1;
      wait_valid(base_v + 1);
      repeat (off) @(negedge clk);
      busy = 1'b0;
      wait_valid(base_v + 2);
      repeat (150) @(negedge clk);
      chk(valid_cnt == base_v + 2, "R10", valid_cnt - base_v, 2);
      chk(result == 12'(12'h5A0 + off), "R10", int'(result), 12'h5A0 + off);
    end
  endtask

  initial begin
    t_reset();
    t_steady();
    t_edge_basic();
    t_leading();
    t_poll();
    t_lsb();
    t_hi();
    t_relaxed();
    t_sel();
    t_hold();
    t_overlap();
    t_collide();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule